// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Sequencer

This block sits beside the pulse-width modulator of a switching converter. Once per switching cycle a cycle-start strobe samples digital comparator flags: a high-side runaway current flag, a low-side sink current flag, an output-undervoltage flag and a soft-start-complete flag. From these it decides when the converter must stop and enter a hiccup fault state. While in hiccup it holds the high-side switch off. It waits a fixed number of switching cycles and then asks for a fresh soft-start.

In full mode the block also counts consecutive sink-limit cycles as a fault trigger. During the timeout it turns the low-side switch on at the start of every cycle. Each such pulse ends when a separate flag reports that the reduced discharge current limit has been reached, so the output capacitor is pulled toward zero. In simple mode only runaway and undervoltage trigger hiccup, and the low side stays off for the whole timeout. Dropping the enable input shuts everything down at once, and the next start begins with a new soft-start.

Top module: `hiccup_seq`

## Requirements
- R1: While running, a single strobe sampled with the runaway flag high makes `hiccup` high and `hs_en` low from the clock edge of that strobe.
- R2: The undervoltage flag triggers hiccup at a strobe only when `ss_done` is also high. With `ss_done` low it has no effect.
- R3: In full mode, hiccup is entered at the 16th consecutive strobe with the sink flag high. A strobe with the sink flag low restarts the count, so 15 such strobes, then one without, then 15 more do not trigger.
- R4: `hiccup` stays high for exactly TIMEOUT_CYC (default 32768) strobes. It falls at the edge of the TIMEOUT_CYC-th strobe after the entry strobe.
- R5: `hs_en` is low whenever `hiccup` is high.
- R6: In full mode during hiccup, `ls_en` is set at every strobe. It is cleared at the first later non-strobe clock at which `dis_flag` is high.
- R7: When the timeout expires, `ss_restart` pulses high for one clock and `hs_en` and `ls_en` return high. A trigger that recurs after the restart re-enters hiccup.
- R8: With `en` low, all four outputs are low after the next clock edge and hiccup is abandoned. The first strobe with `en` high afterwards gives a one-clock `ss_restart` pulse.
- R9: Trigger flags sampled during hiccup neither extend nor restart the timeout.
- R10: In simple mode (`full_mode` low), sink-limit runs never trigger and `ls_en` stays low throughout hiccup.
- R11: After reset all outputs are low and the block waits for a strobe with `en` high.
- R12: The consecutive sink count is cleared on hiccup entry. After a restart, 16 new consecutive sink strobes are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | Switching-cycle start strobe, one clock wide |
| en | input | 1 | Converter enable, high to run |
| full_mode | input | 1 | 1: sink-run trigger and discharge pulsing on; 0: simple variant |
| runaway_flag | input | 1 | High-side runaway current limit reached this cycle |
| sink_flag | input | 1 | Low-side sink current limit reached this cycle |
| uv_flag | input | 1 | Output below undervoltage trip level |
| ss_done | input | 1 | Soft-start has completed |
| dis_flag | input | 1 | Low-side current reached the reduced discharge limit |
| hs_en | output | 1 | High-side switching allowed |
| ls_en | output | 1 | Low-side switching allowed / discharge pulse |
| ss_restart | output | 1 | One-clock request for a new soft-start |
| hiccup | output | 1 | Registered hiccup status |

## Verification
The assertions assume that `full_mode` changes only while `en` is low. They also assume that the flags are meaningful at the strobe, and that `dis_flag` matters only on the clocks between strobes. The stimulus drives every input on the falling clock edge and flips the mode only during disabled intervals. It draws strobes and flags at random, with rare runaway and undervoltage events and frequent sink events so that long sink runs occur. Random enable drops cut hiccups short, which keeps the run inside its cycle budget.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_RUN = 2'd1,
    ST_HIC = 2'd2
  } hc_state_e;
endpackage

// File: rtl/hc_sink_run.sv
module hc_sink_run #(
  parameter int unsigned RUN_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic stb,
  input  logic clr,
  input  logic sink_flag,
  output logic run_done
);
  localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!active) begin
      cnt_d = '0;
    end else if (stb) begin
      if (clr || !sink_flag) cnt_d = '0;
      else                   cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign run_done = active && stb && sink_flag && (cnt_q == CW'(RUN_LEN - 1));

  // R3 / R12: a completed run leaves the count at zero
  p_run_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_done && clr) |=> (cnt_q == '0));
  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(RUN_LEN - 1)));
endmodule

// File: rtl/hc_timer.sv
module hc_timer #(
  parameter int unsigned TIMEOUT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic stb,
  output logic expire
);
  localparam int unsigned TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  logic [TW-1:0] cnt_q, cnt_d;

  assign expire = active && stb && (cnt_q == TW'(TIMEOUT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!active)     cnt_d = '0;
    else if (expire) cnt_d = '0;
    else if (stb)    cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: one step per strobe while the timeout runs
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stb && !expire) |=> (cnt_q == $past(cnt_q) + TW'(1)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !stb) |=> $stable(cnt_q));
endmodule

// File: rtl/hc_trigger.sv
module hc_trigger (
  input  logic runaway_flag,
  input  logic uv_flag,
  input  logic ss_done,
  input  logic sink_trip,
  output logic trig
);
  // undervoltage only counts once soft-start is over
  assign trig = runaway_flag || (uv_flag && ss_done) || sink_trip;
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
  import hiccup_pkg::*;
#(
  parameter int unsigned SINK_RUN    = 16,
  parameter int unsigned TIMEOUT_CYC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_stb,
  input  logic en,
  input  logic full_mode,
  input  logic runaway_flag,
  input  logic sink_flag,
  input  logic uv_flag,
  input  logic ss_done,
  input  logic dis_flag,
  output logic hs_en,
  output logic ls_en,
  output logic ss_restart,
  output logic hiccup
);
  hc_state_e state_q, state_d;
  logic hs_q, hs_d, ls_q, ls_d, ssr_q, ssr_d, hic_q, hic_d;
  logic sink_trip, trig, expire, in_run, in_hic;

  assign in_run = (state_q == ST_RUN);
  assign in_hic = (state_q == ST_HIC);

  hc_sink_run #(.RUN_LEN(SINK_RUN)) u_sink (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (en && full_mode && in_run),
    .stb       (cyc_stb),
    .clr       (cyc_stb && trig),
    .sink_flag (sink_flag),
    .run_done  (sink_trip)
  );

  hc_trigger u_trig (
    .runaway_flag (runaway_flag),
    .uv_flag      (uv_flag),
    .ss_done      (ss_done),
    .sink_trip    (sink_trip),
    .trig         (trig)
  );

  hc_timer #(.TIMEOUT(TIMEOUT_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (en && in_hic),
    .stb    (cyc_stb),
    .expire (expire)
  );

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  if (cyc_stb)           state_d = ST_RUN;
        ST_RUN:  if (cyc_stb && trig)   state_d = ST_HIC;
        ST_HIC:  if (expire)            state_d = ST_RUN;
        default:                        state_d = ST_OFF;
      endcase
    end
  end

  always_comb begin
    hs_d  = en && (state_d == ST_RUN);
    hic_d = en && (state_d == ST_HIC);
    ssr_d = en && cyc_stb && ((state_q == ST_OFF) || expire);
    unique case (state_d)
      ST_RUN:  ls_d = en;
      ST_HIC:  ls_d = cyc_stb ? full_mode : (ls_q && !dis_flag && full_mode);
      default: ls_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
      ssr_q   <= 1'b0;
      hic_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hs_q    <= hs_d;
      ls_q    <= ls_d;
      ssr_q   <= ssr_d;
      hic_q   <= hic_d;
    end
  end

  assign hs_en      = hs_q;
  assign ls_en      = ls_q;
  assign ss_restart = ssr_q;
  assign hiccup     = hic_q;

  p_runaway_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && en && in_run && runaway_flag) |=> (hiccup && !hs_en));
  p_uv_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && en && in_run && uv_flag && !ss_done && !runaway_flag && !sink_flag)
      |=> !hiccup);
  p_expire_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && expire) |=> (!hiccup && hs_en && ss_restart));
  p_hs_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hiccup |-> !hs_en);
  p_pulse_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hiccup && !cyc_stb && dis_flag) |=> !ls_en);
  p_restart_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);
  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_en && !ls_en && !hiccup && !ss_restart));
  p_hold_hic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hiccup && !expire) |=> hiccup);
  p_simple_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hiccup && ls_en) |-> $past(full_mode));
endmodule

// File: tb/hiccup_seq_test.sv
module hiccup_seq_test;
  localparam int T = 32768;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic stb, en, fm, rw, sk, uv, sd, dis;
  logic hs_en, ls_en, ss_restart, hiccup;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model state
  int m_st = 0;
  int m_sink = 0;
  int m_tmr = 0;
  bit m_hs = 0, m_ls = 0, m_ssr = 0, m_hic = 0;

  always #5 clk = ~clk;

  hiccup_seq uut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(stb), .en(en), .full_mode(fm),
    .runaway_flag(rw), .sink_flag(sk), .uv_flag(uv), .ss_done(sd),
    .dis_flag(dis), .hs_en(hs_en), .ls_en(ls_en),
    .ss_restart(ss_restart), .hiccup(hiccup)
  );

  task automatic model_step();
    bit trip;
    if (!en) begin
      m_st = 0; m_sink = 0; m_tmr = 0; m_ssr = 0;
    end else begin
      m_ssr = 0;
      case (m_st)
        0: if (stb) begin m_st = 1; m_ssr = 1; end
        1: if (stb) begin
             trip = rw || (uv && sd) || (fm && sk && m_sink == N - 1);
             if (trip) begin m_st = 2; m_tmr = 0; m_sink = 0; end
             else m_sink = (fm && sk) ? m_sink + 1 : 0;
           end
        default: if (stb) begin
             if (m_tmr == T - 1) begin m_st = 1; m_ssr = 1; m_tmr = 0; end
             else m_tmr = m_tmr + 1;
           end
      endcase
    end
    if (m_st == 1)      m_ls = 1;
    else if (m_st == 2) m_ls = stb ? fm : (m_ls && !dis && fm);
    else                m_ls = 0;
    m_hs  = (m_st == 1);
    m_hic = (m_st == 2);
  endtask

  task automatic check_bit(input string req, input string what, input logic act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string req);
    n_chk++;
    if (hs_en !== m_hs || ls_en !== m_ls || ss_restart !== m_ssr || hiccup !== m_hic) begin
      n_bad++;
      $display("FAIL %s outputs actual=%b%b%b%b expected=%b%b%b%b at %0t", req,
               hs_en, ls_en, ss_restart, hiccup, m_hs, m_ls, m_ssr, m_hic, $time);
    end
  endtask

  task automatic cyc(input bit s, input bit r, input bit k, input bit u,
                     input bit d, input bit x, input string req);
    @(negedge clk);
    stb = s; rw = r; sk = k; uv = u; sd = d; dis = x;
    model_step();
    @(posedge clk);
    #1;
    compare(req);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int hcount;
    void'($urandom(32'd20250611));
    rst_n = 1'b0; stb = 0; en = 0; fm = 1; rw = 0; sk = 0; uv = 0; sd = 0; dis = 0;
    repeat (3) @(posedge clk);
    #1;
    check_bit("R11", "hs_en", hs_en, 0);
    check_bit("R11", "ls_en", ls_en, 0);
    check_bit("R11", "ss_restart", ss_restart, 0);
    check_bit("R11", "hiccup", hiccup, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, "R11");

    // start-up and sink-run boundary (full mode)
    en = 1;
    cyc(1, 0, 0, 0, 0, 0, "R8");
    check_bit("R8", "ss_restart", ss_restart, 1);
    cyc(0, 0, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 15; i++) cyc(1, 0, 1, 0, 1, 0, "R3");
    cyc(1, 0, 0, 0, 1, 0, "R3");
    for (int i = 0; i < 15; i++) cyc(1, 0, 1, 0, 1, 0, "R3");
    check_bit("R3", "hiccup after 15", hiccup, 0);
    cyc(1, 0, 1, 0, 1, 0, "R3");
    check_bit("R3", "hiccup after 16", hiccup, 1);
    check_bit("R5", "hs_en", hs_en, 0);
    check_bit("R6", "ls_en at entry", ls_en, 1);
    cyc(0, 0, 0, 0, 0, 0, "R6");
    check_bit("R6", "ls_en held", ls_en, 1);
    cyc(0, 0, 0, 0, 0, 1, "R6");
    check_bit("R6", "ls_en after discharge flag", ls_en, 0);
    cyc(0, 0, 0, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, 1, "R6");
    check_bit("R6", "ls_en at strobe", ls_en, 1);
    cyc(1, 1, 1, 1, 1, 0, "R9");
    cyc(1, 1, 0, 0, 0, 0, "R9");
    en = 0;
    cyc(0, 0, 0, 0, 0, 0, "R8");
    check_bit("R8", "hiccup disabled", hiccup, 0);
    check_bit("R8", "ls_en disabled", ls_en, 0);
    en = 1;
    cyc(1, 0, 0, 0, 0, 0, "R8");
    check_bit("R8", "restart after enable", ss_restart, 1);

    // undervoltage masking, entry clearing, exact timeout
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 1, 0, 0, "R2");
    check_bit("R2", "uv in soft-start", hiccup, 0);
    for (int i = 0; i < 10; i++) cyc(1, 0, 1, 0, 0, 0, "R12");
    cyc(1, 1, 0, 0, 0, 0, "R1");
    check_bit("R1", "hiccup on runaway", hiccup, 1);
    hcount = 1;
    for (int i = 0; i < T + 10 && hiccup; i++) begin
      cyc(1, 0, 0, 0, 0, (i % 3) == 0, "R4");
      if (hiccup) hcount++;
    end
    n_chk++;
    if (hcount != T) begin
      n_bad++;
      $display("FAIL R4 hiccup length actual=%0d expected=%0d", hcount, T);
    end
    check_bit("R7", "restart on expiry", ss_restart, 1);
    check_bit("R7", "hs_en on expiry", hs_en, 1);
    for (int i = 0; i < 15; i++) cyc(1, 0, 1, 0, 0, 0, "R12");
    check_bit("R12", "no trip after 15 fresh", hiccup, 0);
    cyc(1, 0, 1, 0, 0, 0, "R7");
    check_bit("R7", "re-entry", hiccup, 1);
    en = 0;
    cyc(0, 0, 0, 0, 0, 0, "R8");

    // simple mode
    fm = 0;
    en = 1;
    cyc(1, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 20; i++) cyc(1, 0, 1, 0, 1, 0, "R10");
    check_bit("R10", "sink run ignored", hiccup, 0);
    cyc(1, 0, 0, 1, 1, 0, "R2");
    check_bit("R2", "uv after soft-start", hiccup, 1);
    check_bit("R10", "ls_en idle", ls_en, 0);
    for (int i = 0; i < T + 10 && hiccup; i++) begin
      cyc(1, 0, 0, 0, 0, 0, "R10");
      if (hiccup && ls_en) check_bit("R10", "ls_en in hiccup", ls_en, 0);
    end
    check_bit("R7", "restart simple", ss_restart, 1);

    // constrained random mix
    for (int i = 0; i < 30000; i++) begin
      bit s, r, k, u, d, x;
      if (($urandom % 200) == 0) begin
        en = 0;
        if (($urandom % 2) == 0) fm = ~fm;
      end else begin
        en = 1;
      end
      s = ($urandom % 3) != 0;
      r = ($urandom % 2000) == 0;
      k = ($urandom % 4) != 0;
      u = ($urandom % 500) == 0;
      d = ($urandom % 2) == 0;
      x = ($urandom % 3) == 0;
      cyc(s, r, k, u, d, x, "R5");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule